// File: doc/BRIEF.md
# Adaptive Sequential Block Prefetcher

This block sits beside a cache and watches the stream of block addresses the cache is asked for. When a demand access misses, or when it hits a block that was brought in by a prefetch and is being used for the first time, it looks ahead at the next few sequential block addresses. For each one that is neither present nor already waiting, it queues a prefetch request. Requests leave through a valid/ready handshake, one per cycle.

A small presence directory is built in. It keeps one presence bit and one "prefetched, not yet used" marker bit per block. An invalidate port stands in for evictions, and a lookup port shows both bits of any block.

The lookahead depth `d` adapts at run time. After every window of issued prefetches, the count of prefetches that went on to produce a hit is compared against two percentage thresholds. The comparison uses multiplication, not division. `d` then moves up or down by one. At `d = 0` prefetching is off, and a run of demand misses switches it back on at depth 1.

Top module: `adapt_seq_prefetch`

## Requirements
- R1: An access triggers lookahead when `acc_hit` is 0, or when `acc_hit` is 1 and the block's marker bit is 1. A hit on a block whose marker bit is 0 triggers nothing.
- R2: For a trigger on block b with depth d ≥ 1, the candidates b+1 … b+d (modulo 2^ADDR_W) are examined in ascending order, one per cycle. A candidate that is present, or already queued, is skipped. Every other candidate is queued. The queue never holds two equal addresses.
- R3: `pf_valid`/`pf_addr` stay stable until `pf_ready` is 1, and requests leave in queue order. When the queue is empty, the first request of a trigger is visible after the second rising edge, counting from the edge that samples the access.
- R4: A demand access sets the block's presence bit and clears its marker. An accepted prefetch sets both bits. An invalidate clears both bits. `lk_present`/`lk_tag` show the bits of `lk_addr` combinationally.
- R5: `pf_degree` is 1 after reset. Once WIN_LEN prefetches have been accepted, the window is evaluated and both counters are cleared. If useful×100 > HI_PCT×WIN_LEN, the depth rises by 1 (stopping at MAX_DEG). If useful×100 < LO_PCT×WIN_LEN, the depth falls by 1 (stopping at 0). Otherwise it holds. A useful prefetch is a hit on a block whose marker bit is set.
- R6: While `pf_degree` is 0, no address enters the request queue.
- R7: While `pf_degree` is 0, the REVIVE_MISSES-th demand miss sets it to 1. Hits do not count toward this, and the reviving miss itself does not trigger lookahead.
- R8: A new trigger abandons any candidates of the previous trigger that have not yet been examined.
- R9: When the queue is full, examination stalls on the current candidate. That candidate is queued once space frees up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Demand access strobe |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_hit | input | 1 | 1 when the access hit in the cache |
| inv_valid | input | 1 | Invalidate strobe (eviction) |
| inv_addr | input | ADDR_W | Block to invalidate |
| lk_addr | input | ADDR_W | Directory lookup address |
| lk_present | output | 1 | Presence bit of `lk_addr` |
| lk_tag | output | 1 | Prefetched-unused marker of `lk_addr` |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | ADDR_W | Prefetch request block address |
| pf_ready | input | 1 | Memory side accepts the request |
| pf_degree | output | DEG_W | Current lookahead depth d |

## Verification
The assertions take for granted that `acc_hit` agrees with the presence the directory models. They also assume that a demand access never targets the block being handed out on the same edge. The stimulus keeps both conditions by deriving each hit flag from the blocks it has already touched or seen prefetched. It also leaves several idle cycles after every access, so each trigger finishes examining its candidates before the next access arrives, except where preemption is the thing under test. Back-pressure is applied only by holding `pf_ready` low across whole phases.

// File: rtl/pf_pkg.sv
package pf_pkg;

   typedef enum logic [1:0] {
      MOVE_HOLD = 2'd0,
      MOVE_UP   = 2'd1,
      MOVE_DOWN = 2'd2
   } deg_move_e;

   // Decide the depth move for a finished window; cross-multiplied, no divider.
   function automatic deg_move_e judge_window(input int unsigned useful,
                                              input int unsigned win,
                                              input int unsigned hi_pct,
                                              input int unsigned lo_pct);
      if (useful * 100 > hi_pct * win)
         return MOVE_UP;
      else if (useful * 100 < lo_pct * win)
         return MOVE_DOWN;
      return MOVE_HOLD;
   endfunction

endpackage

// File: rtl/pf_directory.sv
module pf_directory #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dem_en,
   input  logic [ADDR_W-1:0] dem_addr,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              inv_en,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_present,
   output logic              dem_tag,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_present,
   output logic              lk_tag
);
   localparam int NBLK = 1 << ADDR_W;

   logic [NBLK-1:0] present_q;
   logic [NBLK-1:0] tag_q;

   // Demand reference wins over invalidate, which wins over a prefetch fill.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present_q <= '0;
         tag_q     <= '0;
      end else begin
         for (int i = 0; i < NBLK; i++) begin
            if (dem_en && dem_addr == ADDR_W'(i)) begin
               present_q[i] <= 1'b1;
               tag_q[i]     <= 1'b0;
            end else if (inv_en && inv_addr == ADDR_W'(i)) begin
               present_q[i] <= 1'b0;
               tag_q[i]     <= 1'b0;
            end else if (fill_en && fill_addr == ADDR_W'(i)) begin
               present_q[i] <= 1'b1;
               tag_q[i]     <= 1'b1;
            end
         end
      end
   end

   assign probe_present = present_q[probe_addr];
   assign dem_tag       = tag_q[dem_addr];
   assign lk_present    = present_q[lk_addr];
   assign lk_tag        = tag_q[lk_addr];

   AST_DEMAND_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      dem_en |=> (present_q[$past(dem_addr)] && !tag_q[$past(dem_addr)])); // R4

endmodule

// File: rtl/pf_queue.sv
module pf_queue #(
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   output logic              full,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   input  logic              out_ready
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [ADDR_W-1:0] slot_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              do_pop;
   logic [CNT_W-1:0]  wr_idx;

   assign out_valid = (cnt_q != '0);
   assign out_addr  = slot_q[0];
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign do_pop    = out_valid && out_ready;
   assign wr_idx    = do_pop ? cnt_q - CNT_W'(1) : cnt_q;

   always_comb begin
      probe_hit = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (CNT_W'(i) < cnt_q && slot_q[i] == probe_addr)
            probe_hit = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++)
            slot_q[i] <= '0;
      end else begin
         if (do_pop)
            for (int i = 0; i < DEPTH - 1; i++)
               slot_q[i] <= slot_q[i+1];
         if (push)
            for (int i = 0; i < DEPTH; i++)
               if (wr_idx == CNT_W'(i))
                  slot_q[i] <= push_addr;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(do_pop);
      end
   end

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R3

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_uniq_i
      for (genvar gj = gi + 1; gj < DEPTH; gj++) begin : g_uniq_j
         AST_NO_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q > CNT_W'(gj)) |-> (slot_q[gi] != slot_q[gj])); // R2
      end
   end

endmodule

// File: rtl/pf_degree_ctl.sv
module pf_degree_ctl
   import pf_pkg::*;
#(
   parameter int MAX_DEG       = 4,
   parameter int WIN_LEN       = 8,
   parameter int HI_PCT        = 75,
   parameter int LO_PCT        = 25,
   parameter int REVIVE_MISSES = 4,
   localparam int DEG_W        = $clog2(MAX_DEG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issued,
   input  logic             useful,
   input  logic             miss,
   output logic [DEG_W-1:0] degree
);
   localparam int WIN_W = $clog2(WIN_LEN + 1);
   localparam int REV_W = $clog2(REVIVE_MISSES + 1);

   logic [DEG_W-1:0] deg_q;
   logic [WIN_W-1:0] iss_q;
   logic [WIN_W-1:0] use_q;
   logic [REV_W-1:0] miss_q;
   logic             win_done;
   deg_move_e        move;

   assign win_done = (iss_q == WIN_W'(WIN_LEN));
   assign move     = judge_window(32'(use_q), WIN_LEN, HI_PCT, LO_PCT);
   assign degree   = deg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deg_q  <= DEG_W'(1);
         iss_q  <= '0;
         use_q  <= '0;
         miss_q <= '0;
      end else begin
         if (win_done) begin
            iss_q <= WIN_W'(issued);
            use_q <= WIN_W'(useful);
            if (move == MOVE_UP && deg_q != DEG_W'(MAX_DEG))
               deg_q <= deg_q + DEG_W'(1);
            else if (move == MOVE_DOWN && deg_q != '0)
               deg_q <= deg_q - DEG_W'(1);
         end else begin
            iss_q <= iss_q + WIN_W'(issued);
            if (useful && use_q != WIN_W'(WIN_LEN))
               use_q <= use_q + WIN_W'(1);
         end
         if (deg_q == '0) begin
            if (miss) begin
               if (miss_q == REV_W'(REVIVE_MISSES - 1)) begin
                  deg_q  <= DEG_W'(1);
                  miss_q <= '0;
               end else begin
                  miss_q <= miss_q + REV_W'(1);
               end
            end
         end else begin
            miss_q <= '0;
         end
      end
   end

   AST_DEG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      deg_q <= DEG_W'(MAX_DEG)); // R5
   AST_DEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(deg_q) |-> ((deg_q == $past(deg_q) + DEG_W'(1)) ||
                           ($past(deg_q) == deg_q + DEG_W'(1)))); // R5
   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      iss_q <= WIN_W'(WIN_LEN)); // R5

endmodule

// File: rtl/adapt_seq_prefetch.sv
module adapt_seq_prefetch
   import pf_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int QUEUE_DEPTH   = 4,
   parameter int MAX_DEG       = 4,
   parameter int WIN_LEN       = 8,
   parameter int HI_PCT        = 75,
   parameter int LO_PCT        = 25,
   parameter int REVIVE_MISSES = 4,
   localparam int DEG_W        = $clog2(MAX_DEG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_hit,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_present,
   output logic              lk_tag,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr,
   input  logic              pf_ready,
   output logic [DEG_W-1:0]  pf_degree
);
   initial begin : elab_checks
      assert (ADDR_W >= 2 && ADDR_W <= 12) else $error("ADDR_W out of range");
      assert (QUEUE_DEPTH >= 2) else $error("QUEUE_DEPTH must be at least 2");
      assert (MAX_DEG >= 1 && MAX_DEG < (1 << ADDR_W)) else $error("MAX_DEG out of range");
      assert (WIN_LEN >= 1) else $error("WIN_LEN must be positive");
      assert (LO_PCT <= HI_PCT && HI_PCT <= 100) else $error("thresholds out of order");
      assert (REVIVE_MISSES >= 1) else $error("REVIVE_MISSES must be positive");
   end

   logic              acc_tag;
   logic              trig, useful, miss;
   logic              wk_busy;
   logic [ADDR_W-1:0] wk_base;
   logic [DEG_W-1:0]  wk_off, wk_lim;
   logic [ADDR_W-1:0] cand;
   logic              cand_present, cand_queued, skip;
   logic              q_full, q_push, wk_step, pf_take;
   logic [DEG_W-1:0]  deg_now;

   assign trig    = acc_valid && (!acc_hit || acc_tag);
   assign useful  = acc_valid && acc_hit && acc_tag;
   assign miss    = acc_valid && !acc_hit;
   assign pf_take = pf_valid && pf_ready;
   assign cand    = wk_base + ADDR_W'(wk_off);
   assign skip    = cand_present || cand_queued;
   assign q_push  = wk_busy && (deg_now != '0) && !skip && !q_full;
   assign wk_step = wk_busy && (skip || !q_full);
   assign pf_degree = deg_now;

   pf_directory #(.ADDR_W(ADDR_W)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .dem_en(acc_valid), .dem_addr(acc_addr),
      .fill_en(pf_take), .fill_addr(pf_addr),
      .inv_en(inv_valid), .inv_addr(inv_addr),
      .probe_addr(cand), .probe_present(cand_present),
      .dem_tag(acc_tag),
      .lk_addr(lk_addr), .lk_present(lk_present), .lk_tag(lk_tag)
   );

   pf_queue #(.ADDR_W(ADDR_W), .DEPTH(QUEUE_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_addr(cand), .full(q_full),
      .probe_addr(cand), .probe_hit(cand_queued),
      .out_valid(pf_valid), .out_addr(pf_addr), .out_ready(pf_ready)
   );

   pf_degree_ctl #(
      .MAX_DEG(MAX_DEG), .WIN_LEN(WIN_LEN), .HI_PCT(HI_PCT),
      .LO_PCT(LO_PCT), .REVIVE_MISSES(REVIVE_MISSES)
   ) u_deg (
      .clk(clk), .rst_n(rst_n),
      .issued(pf_take), .useful(useful), .miss(miss),
      .degree(deg_now)
   );

   // Lookahead walker: one candidate per cycle, newest trigger wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wk_busy <= 1'b0;
         wk_base <= '0;
         wk_off  <= '0;
         wk_lim  <= '0;
      end else if (trig && deg_now != '0) begin
         wk_busy <= 1'b1;
         wk_base <= acc_addr;
         wk_off  <= DEG_W'(1);
         wk_lim  <= deg_now;
      end else if (deg_now == '0) begin
         wk_busy <= 1'b0;
      end else if (wk_step) begin
         if (wk_off == wk_lim)
            wk_busy <= 1'b0;
         else
            wk_off <= wk_off + DEG_W'(1);
      end
   end

   AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (deg_now == '0 && !pf_valid) |=> !pf_valid); // R6

endmodule

// File: tb/adapt_seq_prefetch_tb.sv
`timescale 1ns/1ps
module adapt_seq_prefetch_tb;
   localparam int AW = 6;
   localparam int NVEC = 10;
   // {addr[17:12], hit[11], new requests[10:9], first request[8:3], depth after[2:0]}
   localparam logic [17:0] VEC [NVEC] = '{
      {6'd10, 1'b0, 2'd1, 6'd11, 3'd1},
      {6'd11, 1'b1, 2'd1, 6'd12, 3'd1},
      {6'd11, 1'b1, 2'd0, 6'd0,  3'd1},
      {6'd12, 1'b1, 2'd1, 6'd13, 3'd1},
      {6'd9,  1'b0, 2'd0, 6'd0,  3'd1},
      {6'd13, 1'b1, 2'd1, 6'd14, 3'd1},
      {6'd14, 1'b1, 2'd1, 6'd15, 3'd1},
      {6'd15, 1'b1, 2'd1, 6'd16, 3'd1},
      {6'd16, 1'b1, 2'd1, 6'd17, 3'd1},
      {6'd17, 1'b1, 2'd1, 6'd18, 3'd2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_hit = 1'b0, inv_valid = 1'b0, pf_ready = 1'b1;
   logic [AW-1:0] acc_addr = '0, inv_addr = '0, lk_addr = '0;
   logic lk_present, lk_tag, pf_valid;
   logic [AW-1:0] pf_addr;
   logic [2:0] pf_degree;

   int n_tests = 0, n_fail = 0;
   logic [AW-1:0] log_q [256];
   int log_n = 0;
   int mark;

   always #2.5 clk = ~clk;

   adapt_seq_prefetch u_dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_hit(acc_hit),
      .inv_valid(inv_valid), .inv_addr(inv_addr),
      .lk_addr(lk_addr), .lk_present(lk_present), .lk_tag(lk_tag),
      .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready),
      .pf_degree(pf_degree)
   );

   // Record every handshake, sampled mid-cycle.
   always @(negedge clk)
      if (rst_n && pf_valid && pf_ready && log_n < 256) begin
         log_q[log_n] = pf_addr;
         log_n++;
      end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic access(input int a, input bit h);
      acc_addr = AW'(a);
      acc_hit = h;
      acc_valid = 1'b1;
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
   endtask

   task automatic look(input string req, input int a, input int exp_p, input int exp_t);
      lk_addr = AW'(a);
      #1;
      chk(req, $sformatf("present of block %0d", a), int'(lk_present), exp_p);
      chk(req, $sformatf("marker of block %0d", a), int'(lk_tag), exp_t);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // Reset state
      chk("R5", "depth after reset", int'(pf_degree), 1);
      chk("R3", "valid after reset", int'(pf_valid), 0);
      look("R4", 10, 0, 0);

      // Vector table: R1 triggers, R2 candidates, R5 window at depth 1 -> 2
      for (int v = 0; v < NVEC; v++) begin
         mark = log_n;
         access(int'(VEC[v][17:12]), VEC[v][11]);
         idle(8);
         chk("R1/R2", $sformatf("vector %0d request count", v), log_n - mark, int'(VEC[v][10:9]));
         if (VEC[v][10:9] != 2'd0)
            chk("R2", $sformatf("vector %0d request address", v), int'(log_q[mark]), int'(VEC[v][8:3]));
         chk("R5", $sformatf("vector %0d depth", v), int'(pf_degree), int'(VEC[v][2:0]));
      end

      // R3 timing and R2 two-deep lookahead on first use of prefetched block 18
      mark = log_n;
      access(18, 1'b1);
      chk("R3", "valid one edge after access", int'(pf_valid), 0);
      idle(1);
      chk("R3", "valid two edges after access", int'(pf_valid), 1);
      chk("R3", "first address", int'(pf_addr), 19);
      idle(1);
      chk("R3", "second address", int'(pf_addr), 20);
      idle(6);
      chk("R2", "depth-2 request count", log_n - mark, 2);
      chk("R2", "depth-2 order", int'(log_q[mark + 1]), 20);

      // R4 directory bits
      look("R4", 19, 1, 1);
      look("R4", 18, 1, 0);
      look("R4", 40, 0, 0);
      inv_addr = AW'(19);
      inv_valid = 1'b1;
      @(posedge clk);
      #1;
      inv_valid = 1'b0;
      look("R4", 19, 0, 0);

      // R3 hold, R2 queued skip, R9 full stall, R8 preemption
      idle(1);
      pf_ready = 1'b0;
      mark = log_n;
      access(30, 1'b0);
      idle(6);
      chk("R3", "head under back-pressure", int'(pf_addr), 31);
      idle(4);
      chk("R3", "head held", int'(pf_addr), 31);
      chk("R3", "valid held", int'(pf_valid), 1);
      access(29, 1'b0);
      idle(4);
      access(40, 1'b0);
      idle(6);
      access(50, 1'b0);
      idle(4);
      access(60, 1'b0);
      idle(4);
      chk("R3", "nothing taken while not ready", log_n - mark, 0);
      pf_ready = 1'b1;
      idle(12);
      chk("R9", "requests after release", log_n - mark, 6);
      chk("R2", "queued block not repeated", int'(log_q[mark + 1]), 32);
      chk("R9", "order third", int'(log_q[mark + 2]), 41);
      chk("R9", "stalled candidate kept", int'(log_q[mark + 4]), 61);
      chk("R8", "last after preemption", int'(log_q[mark + 5]), 62);
      look("R8", 51, 0, 0);
      chk("R5", "depth falls on poor window", int'(pf_degree), 1);

      // R5 fall to zero; R2 wrap-around
      mark = log_n;
      foreach (VEC[k]) begin end
      access(44, 1'b0); idle(6);
      access(46, 1'b0); idle(6);
      access(48, 1'b0); idle(6);
      access(52, 1'b0); idle(6);
      access(54, 1'b0); idle(6);
      access(56, 1'b0); idle(6);
      access(58, 1'b0); idle(6);
      access(63, 1'b0); idle(6);
      chk("R2", "single requests at depth 1", log_n - mark, 8);
      chk("R2", "wrap past top block", int'(log_q[mark + 7]), 0);
      chk("R5", "depth reaches zero", int'(pf_degree), 0);

      // R6 silence and R7 revival
      mark = log_n;
      access(24, 1'b0); idle(6);
      chk("R6", "no request at depth 0", log_n - mark, 0);
      chk("R6", "valid low at depth 0", int'(pf_valid), 0);
      access(26, 1'b0); idle(4);
      access(45, 1'b1); idle(4);
      chk("R6", "first use at depth 0 silent", log_n - mark, 0);
      access(22, 1'b0); idle(4);
      chk("R7", "three misses keep depth 0", int'(pf_degree), 0);
      access(27, 1'b0); idle(6);
      chk("R7", "fourth miss revives", int'(pf_degree), 1);
      chk("R7", "reviving miss issues nothing", log_n - mark, 0);
      access(36, 1'b0); idle(6);
      chk("R7", "request after revival", log_n - mark, 1);
      chk("R7", "revived address", int'(log_q[mark]), 37);

      finish_run();
   end
endmodule